// File: doc/BRIEF.md
# Serial Memory Pin Ownership Arbiter

This block decides who drives the four pins of a serial configuration memory: the on-chip engines that read and auto-load it, or software that toggles the pins by hand through one control register. Software sets a request bit and then polls a grant bit. The grant is withheld while an engine is in the middle of a transfer. Once granted, three register bits drive the clock, select and data-out pins directly. The data-in pin can be read back through a synchronizer. The memory command protocol is therefore entirely a matter for software.

Ownership is tracked by a four-state machine:
- `OWN_HW`: the engines drive the pins.
- `OWN_WAIT`: a request is pending, but an engine is busy or holds chip select.
- `OWN_SW`: software holds the grant.
- `OWN_RELEASE`: a one-cycle handover in which all pins are driven low.

The transitions are:
- `OWN_HW`→`OWN_SW` when the request is set and the engines are idle.
- `OWN_HW`→`OWN_WAIT` when the request is set and an engine is active.
- `OWN_WAIT`→`OWN_SW` when the engines become idle.
- `OWN_WAIT`→`OWN_HW` when the request is withdrawn.
- `OWN_SW`→`OWN_RELEASE` when the request is cleared.
- `OWN_RELEASE`→`OWN_HW` unconditionally.

While the grant is held, an engine that asks for the pins is told to stall.

Control register layout (8 bits):

| Bit | Function | Access |
|-----|----------|--------|
| 0 | clock | read/write |
| 1 | chip select, active high | read/write |
| 2 | data to memory | read/write |
| 3 | data from memory | read-only |
| 6 | request | read/write |
| 7 | grant | read-only |

Bits 4 and 5 read as 0.

Top module: `eeprom_pin_arbiter`

## Requirements
- R1: After reset (active-low `rst_n`, asynchronous), `reg_rdata` reads 0, the state is `OWN_HW`, and the pins follow the engine inputs.
- R2: A write with bit 6 = 1 sets the request, which reads back as bit 6 from the cycle after the write.
- R3: The grant (bit 7) rises only on a clock edge at which `hw_busy` = 0 and `hw_cs` = 0. While either input is high, the grant stays 0.
- R4: Once granted, the grant stays 1 for as long as the request bit stays 1, whatever `hw_busy` does.
- R5: While granted, `ee_sclk`, `ee_cs` and `ee_do` equal written bits 0, 1 and 2. A write changes the pins at the clock edge that captures it, not before.
- R6: Bit 3 returns `ee_di` through `SYNC_STAGES` flops while granted. It reads 0 when not granted.
- R7: Write data in bits 7, 3, 5 and 4 is ignored: the grant is not forced, and those bits read 0 when not granted.
- R8: `hw_stall` = `hw_req` in `OWN_SW` and `OWN_RELEASE`, and 0 otherwise.
- R9: After the request is cleared, the grant reads 0 from the next clock edge, and all three driven pins are 0 for one cycle (`OWN_RELEASE`).
- R10: Outside `OWN_SW` and `OWN_RELEASE`, the pins follow `hw_sclk`, `hw_cs` and `hw_do` combinationally.
- R11: A request withdrawn in `OWN_WAIT` returns the block to `OWN_HW` without the grant ever rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| hw_busy | input | 1 | An internal engine is mid-transaction |
| hw_req | input | 1 | An internal engine wants the pins |
| hw_stall | output | 1 | Engine must hold off |
| hw_sclk | input | 1 | Engine-driven clock |
| hw_cs | input | 1 | Engine-driven chip select |
| hw_do | input | 1 | Engine-driven data out |
| ee_sclk | output | 1 | Memory clock pin |
| ee_cs | output | 1 | Memory chip select pin |
| ee_do | output | 1 | Memory data-in pin (driven by this block) |
| ee_di | input | 1 | Memory data-out pin |

## Verification
The grant rule is tried in four situations: the request arrives while `hw_busy` is high; `hw_busy` is low but `hw_cs` is still high; both are low; and the request is withdrawn before the engines go idle. Together these separate a grant gated on both conditions from one gated on either alone, and from one that latches a stale request. While granted, the bench holds the engine pins at the complement of every software pin pattern in turn, so a wrong multiplexer leg or a swapped bit shows on the pins. It also samples the pins before the write edge, which exposes any latency error. The release is checked in the handover cycle, where all pins must be low even though the engine pins are high. That is the point where a design that skips the handover would differ.

// File: rtl/eeprom_arb_pkg.sv
package eeprom_arb_pkg;
    localparam int CTRL_W   = 8;
    localparam int BIT_SCLK = 0;
    localparam int BIT_CS   = 1;
    localparam int BIT_DO   = 2;
    localparam int BIT_DI   = 3;
    localparam int BIT_REQ  = 6;
    localparam int BIT_GNT  = 7;

    typedef enum logic [1:0] {
        OWN_HW      = 2'd0,
        OWN_WAIT    = 2'd1,
        OWN_SW      = 2'd2,
        OWN_RELEASE = 2'd3
    } own_state_t;

    typedef struct packed {
        logic sclk;
        logic cs;
        logic dout;
    } pin_set_t;
endpackage

// File: rtl/eeprom_ctl_reg.sv
module eeprom_ctl_reg
    import eeprom_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_req,
    input  pin_set_t wr_pins,
    output logic     sw_req,
    output pin_set_t sw_pins
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_req  <= 1'b0;
            sw_pins <= '0;
        end else if (wr_en) begin
            sw_req  <= wr_req;
            sw_pins <= wr_pins;
        end
    end
endmodule

// File: rtl/eeprom_own_fsm.sv
module eeprom_own_fsm
    import eeprom_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic hw_busy,
    input  logic hw_cs,
    input  logic hw_req,
    output logic grant,
    output logic sw_drive,
    output logic idle_drive,
    output logic hw_stall
);
    own_state_t state_q, state_d;
    logic       hw_quiet;

    assign hw_quiet = !hw_busy && !hw_cs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_HW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        grant      = 1'b0;
        sw_drive   = 1'b0;
        idle_drive = 1'b0;
        hw_stall   = 1'b0;
        unique case (state_q)
            OWN_HW: begin
                if (sw_req) state_d = hw_quiet ? OWN_SW : OWN_WAIT;
            end
            OWN_WAIT: begin
                if (!sw_req)       state_d = OWN_HW;
                else if (hw_quiet) state_d = OWN_SW;
            end
            OWN_SW: begin
                grant    = 1'b1;
                sw_drive = 1'b1;
                hw_stall = hw_req;
                if (!sw_req) state_d = OWN_RELEASE;
            end
            OWN_RELEASE: begin
                idle_drive = 1'b1;
                hw_stall   = hw_req;
                state_d    = OWN_HW;
            end
            default: state_d = OWN_HW;
        endcase
    end
endmodule

// File: rtl/eeprom_pin_mux.sv
module eeprom_pin_mux
    import eeprom_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_drive,
    input  logic     idle_drive,
    input  pin_set_t sw_pins,
    input  pin_set_t hw_pins,
    input  logic     ee_di,
    output pin_set_t pins,
    output logic     di_sync
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ee_di;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ee_di};
            end
        end
    endgenerate

    assign di_sync = sync_q[SYNC_STAGES-1];

    always_comb begin
        if (sw_drive)        pins = sw_pins;
        else if (idle_drive) pins = '0;
        else                 pins = hw_pins;
    end
endmodule

// File: rtl/eeprom_pin_arbiter.sv
module eeprom_pin_arbiter
    import eeprom_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              hw_busy,
    input  logic              hw_req,
    output logic              hw_stall,
    input  logic              hw_sclk,
    input  logic              hw_cs,
    input  logic              hw_do,
    output logic              ee_sclk,
    output logic              ee_cs,
    output logic              ee_do,
    input  logic              ee_di
);
    pin_set_t wr_pins, sw_pins, hw_pins, pins;
    logic     sw_req, grant, sw_drive, idle_drive, di_sync;
    logic     wire_unused;

    assign wr_pins     = '{sclk: reg_wdata[BIT_SCLK], cs: reg_wdata[BIT_CS], dout: reg_wdata[BIT_DO]};
    assign hw_pins     = '{sclk: hw_sclk, cs: hw_cs, dout: hw_do};
    assign wire_unused = ^{reg_wdata[BIT_GNT], reg_wdata[5:4], reg_wdata[BIT_DI]};

    eeprom_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_req  (reg_wdata[BIT_REQ]),
        .wr_pins (wr_pins),
        .sw_req  (sw_req),
        .sw_pins (sw_pins)
    );

    eeprom_own_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_req     (sw_req),
        .hw_busy    (hw_busy),
        .hw_cs      (hw_cs),
        .hw_req     (hw_req),
        .grant      (grant),
        .sw_drive   (sw_drive),
        .idle_drive (idle_drive),
        .hw_stall   (hw_stall)
    );

    eeprom_pin_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_drive   (sw_drive),
        .idle_drive (idle_drive),
        .sw_pins    (sw_pins),
        .hw_pins    (hw_pins),
        .ee_di      (ee_di),
        .pins       (pins),
        .di_sync    (di_sync)
    );

    assign ee_sclk = pins.sclk;
    assign ee_cs   = pins.cs;
    assign ee_do   = pins.dout;

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[BIT_SCLK] = sw_pins.sclk;
        reg_rdata[BIT_CS]   = sw_pins.cs;
        reg_rdata[BIT_DO]   = sw_pins.dout;
        reg_rdata[BIT_DI]   = grant & di_sync;
        reg_rdata[BIT_REQ]  = sw_req;
        reg_rdata[BIT_GNT]  = grant;
    end
endmodule

// File: rtl/eeprom_pin_arbiter_chk.sv
module eeprom_pin_arbiter_chk
    import eeprom_arb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] reg_rdata,
    input logic              hw_busy,
    input logic              hw_req,
    input logic              hw_stall,
    input logic              hw_sclk,
    input logic              hw_cs,
    input logic              hw_do,
    input logic              ee_sclk,
    input logic              ee_cs,
    input logic              ee_do
);
    logic gnt, req;
    assign gnt = reg_rdata[BIT_GNT];
    assign req = reg_rdata[BIT_REQ];

    // R3
    grant_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt) |-> $past(!hw_busy && !hw_cs));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt && req |=> gnt);

    // R9
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt && !req |=> !gnt && !ee_cs && !ee_sclk && !ee_do);

    // R8
    stall_when_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt && hw_req |-> hw_stall);

    // R8
    no_stall_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt && $past(!gnt) |-> !hw_stall);

    // R5
    sw_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> ee_sclk == reg_rdata[BIT_SCLK] && ee_cs == reg_rdata[BIT_CS]
                && ee_do == reg_rdata[BIT_DO]);

    // R10
    hw_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt && $past(!gnt) |-> ee_sclk == hw_sclk && ee_cs == hw_cs && ee_do == hw_do);

    // R6
    di_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt |-> !reg_rdata[BIT_DI]);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5:4] == 2'b00);
endmodule

bind eeprom_pin_arbiter eeprom_pin_arbiter_chk u_chk (.*);

// File: tb/eeprom_pin_arbiter_bench.sv
module eeprom_pin_arbiter_bench;
    localparam int SYNC = 2;
    localparam logic [2:0] PAT [8] = '{3'b001, 3'b010, 3'b100, 3'b011,
                                       3'b110, 3'b101, 3'b111, 3'b000};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       hw_busy = 1'b0, hw_req = 1'b0, hw_stall;
    logic       hw_sclk = 1'b0, hw_cs = 1'b0, hw_do = 1'b0;
    logic       ee_sclk, ee_cs, ee_do;
    logic       ee_di = 1'b0;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    eeprom_pin_arbiter #(.SYNC_STAGES(SYNC)) u_eeprom_pin_arbiter (.*);

    function automatic logic [2:0] pins();
        return {ee_do, ee_cs, ee_sclk};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [2:0] prev;
        {hw_do, hw_cs, hw_sclk} = 3'b101;
        hw_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 rdata", reg_rdata, 8'h00);
        check("R10 pins follow hw", {5'b0, pins()}, 8'h05);
        check("R8 no stall", {7'b0, hw_stall}, 8'h00);

        // R2/R3: request under busy, then under chip select, then quiet
        hw_busy = 1'b1;
        {hw_do, hw_cs, hw_sclk} = 3'b000;
        wr(8'h40);
        check("R2 request bit", {7'b0, reg_rdata[6]}, 8'h01);
        repeat (3) @(negedge clk);
        check("R3 busy holds grant", {7'b0, reg_rdata[7]}, 8'h00);
        hw_busy = 1'b0;
        hw_cs = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 cs holds grant", {7'b0, reg_rdata[7]}, 8'h00);
        hw_cs = 1'b0;
        @(negedge clk);
        check("R3 grant when quiet", {7'b0, reg_rdata[7]}, 8'h01);

        // R4/R8
        hw_busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 grant kept", {7'b0, reg_rdata[7]}, 8'h01);
        check("R8 stall while owned", {7'b0, hw_stall}, 8'h01);

        // R5 vector table
        prev = 3'b000;
        foreach (PAT[i]) begin
            {hw_do, hw_cs, hw_sclk} = ~PAT[i];
            @(negedge clk);
            reg_wr_en = 1'b1;
            reg_wdata = {5'b01000, PAT[i]};
            #1;
            check("R5 no early change", {5'b0, pins()}, {5'b0, prev});
            @(negedge clk);
            reg_wr_en = 1'b0;
            #1;
            check("R5 pin pattern", {5'b0, pins()}, {5'b0, PAT[i]});
            prev = PAT[i];
        end

        // R6
        ee_di = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        check("R6 di high", {7'b0, reg_rdata[3]}, 8'h01);
        ee_di = 1'b0;
        repeat (SYNC + 1) @(negedge clk);
        check("R6 di low", {7'b0, reg_rdata[3]}, 8'h00);

        // R9 release
        {hw_do, hw_cs, hw_sclk} = 3'b111;
        wr(8'h07);
        check("R9 request cleared", {7'b0, reg_rdata[6]}, 8'h00);
        @(negedge clk);
        check("R9 grant dropped", {7'b0, reg_rdata[7]}, 8'h00);
        check("R9 pins idle", {5'b0, pins()}, 8'h00);
        @(negedge clk);
        check("R10 hw pins back", {5'b0, pins()}, 8'h07);
        check("R8 stall released", {7'b0, hw_stall}, 8'h00);

        // R7 read-only bits
        ee_di = 1'b1;
        wr(8'hB8);
        repeat (3) @(negedge clk);
        check("R7 grant not forced", {7'b0, reg_rdata[7]}, 8'h00);
        check("R7 ro bits read zero", {4'b0, reg_rdata[6:3]}, 8'h00);
        ee_di = 1'b0;

        // R11 withdraw while waiting
        wr(8'h40);
        repeat (2) @(negedge clk);
        check("R11 waiting no grant", {7'b0, reg_rdata[7]}, 8'h00);
        wr(8'h00);
        hw_busy = 1'b0;
        {hw_do, hw_cs, hw_sclk} = 3'b000;
        repeat (3) @(negedge clk);
        check("R11 no grant after withdraw", {7'b0, reg_rdata[7]}, 8'h00);

        // R1 reset while granted
        wr(8'h47);
        @(negedge clk);
        check("R3 grant regained", {7'b0, reg_rdata[7]}, 8'h01);
        check("R5 pins driven", {5'b0, pins()}, 8'h07);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears", reg_rdata, 8'h00);
        check("R1 pins to hw", {5'b0, pins()}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule